// File: doc/BRIEF.md
# Dual-Channel Multifrequency Signalling Control Port

This block is the processor-facing register port of a two-channel multifrequency (MF) signalling transceiver. A byte-wide bus selects one of two identical channel banks with one address bit. Each bank holds two configuration bytes and a transmit command register, and it provides a status register for reads. The configuration bytes decode into per-channel mode bits that drive the rest of the transceiver: codec clock source, digit format (2-of-6 or 4-bit binary), channel enable, long or short KP detection time, KP-gated detection, and companding law.

A transmit command carries a tone-pair code in the format that the channel's format bit currently selects. The bank checks the code, and on success it drives a per-channel tone-active output and a 6-bit tone selection toward an external tone generator. A code field of zero turns the tone off. A disabled channel ignores every transmit command, including tone-off, but it keeps a tone that was already running. Tone synthesis, companding and codec serial timing sit outside this block.

Top module: `mf_ctrl_port`

## Requirements
- R1: After reset, every mode output is 0, no tone is active, every tone_code bit is 0, bus_rdata is 0 and every register reads back as 0.
- R2: A write to register 0 (config A) of a channel sets that channel's enable from data bit 0, its format from bit 1 (1 = binary, 0 = 2-of-6) and its companding law from bit 2 (1 = A-law, 0 = µ-law). Bits 7:3 are ignored.
- R3: A write to register 1 (config B) sets the external codec clock select from bit 0, long KP detection from bit 1 and KP-gated detection from bit 2. Bits 7:3 are ignored.
- R4: bus_addr[2] selects the channel and bus_addr[1:0] selects the register. A write to one channel leaves every output and register of the other channel unchanged.
- R5: In 2-of-6 mode, a transmit command (register 2) on an enabled channel whose bits 5:0 have exactly two bits set starts the tone and sets tone_code to bits 5:0. Bits 7:6 are ignored.
- R6: In 2-of-6 mode, a nonzero code field on an enabled channel that does not have exactly two bits set is rejected. The tone state and tone_code stay unchanged and the error flag (status bit 1) is set.
- R7: In binary mode, a transmit command on an enabled channel with a nonzero bits 3:0 starts the tone and sets tone_code to {2'b00, bits 3:0}. Bits 7:4 are ignored.
- R8: A transmit command on an enabled channel whose code field (bits 5:0 in 2-of-6 mode, bits 3:0 in binary mode) is zero stops the tone and clears tone_code. Every accepted command clears the error flag.
- R9: On a disabled channel, every transmit command, including tone-off and malformed codes, leaves the tone state, tone_code and the error flag unchanged.
- R10: Clearing a channel's enable bit does not stop a running tone. The tone and its code stay until a tone-off command arrives on the enabled channel.
- R11: A read (bus_sel=1, bus_we=0) loads bus_rdata at the next rising edge. Register 0 reads {5'b0, law, format, enable}, register 1 reads {5'b0, kp_gate, kp_long, ext_clk}, register 2 reads {2'b0, tone_code} and register 3 reads {6'b0, error, tone_active}. bus_rdata holds its value on cycles without a read.
- R12: No register changes unless bus_sel is 1. All updates happen at the rising edge of clk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Bit 2 selects the channel, bits 1:0 select the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tone_on | output | 2 | Tone active, one bit per channel |
| tone_code | output | 12 | Tone-pair selection, 6 bits per channel (channel 0 in bits 5:0) |
| cfg_ext_clk | output | 2 | External codec clock select per channel |
| cfg_bin | output | 2 | Binary digit format per channel |
| cfg_en | output | 2 | Channel enable |
| cfg_kp_long | output | 2 | Long KP detection time per channel |
| cfg_kp_gate | output | 2 | Detection gated by KP per channel |
| cfg_alaw | output | 2 | Companding law per channel (1 = A-law) |

## Verification
Every configuration and tone register drives a port directly, so a wrong decode or a write landing in the wrong bank shows on the mode or tone outputs at the first falling edge after the offending write. Faults in the error flag and in the read path stay hidden until the status or command register is read back, and they appear one cycle after that read strobe. For that reason, each rejected or ignored command is followed by a status read. The hardest fault to expose is a disabled channel that wrongly acts on tone-off. It can only be seen by leaving a tone running across a disable and then sending tone-off.

// File: rtl/mf_ctrl_pkg.sv
package mf_ctrl_pkg;

  localparam int BYTE_W = 8;
  localparam int CODE_W = 6;
  localparam int BIN_W  = 4;
  localparam int NREG   = 4;
  localparam int VIEW_W = NREG * BYTE_W;

  typedef enum logic [1:0] {
    REG_CFG_A = 2'd0,
    REG_CFG_B = 2'd1,
    REG_TXCMD = 2'd2,
    REG_STAT  = 2'd3
  } reg_sel_e;

  // packed MSB first: en lands on bit 0
  typedef struct packed {
    logic alaw;
    logic bin;
    logic en;
  } cfg_a_t;

  typedef struct packed {
    logic kp_gate;
    logic kp_long;
    logic ext_clk;
  } cfg_b_t;

endpackage

// File: rtl/mf_code_check.sv
module mf_code_check
  import mf_ctrl_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int BW = BIN_W
) (
  input  logic [BYTE_W-1:0] cmd,
  input  logic              bin_mode,
  output logic [CW-1:0]     field,
  output logic              is_off,
  output logic              is_bad
);

  localparam int CNT_W = $clog2(CW + 1);

  logic [CNT_W-1:0] ones;

  always_comb begin
    if (bin_mode) begin
      field = {{(CW-BW){1'b0}}, cmd[BW-1:0]};
    end else begin
      field = cmd[CW-1:0];
    end
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < CW; i++) begin
      ones = ones + CNT_W'(field[i]);
    end
  end

  assign is_off = (field == '0);
  assign is_bad = !bin_mode && !is_off && (ones != CNT_W'(2));

endmodule

// File: rtl/mf_chan_bank.sv
module mf_chan_bank
  import mf_ctrl_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int BW = BIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  reg_sel_e          reg_sel,
  input  logic [BYTE_W-1:0] wdata,
  output cfg_a_t            cfg_a,
  output cfg_b_t            cfg_b,
  output logic              tone_on,
  output logic [CW-1:0]     tone_code,
  output logic [VIEW_W-1:0] reg_view
);

  cfg_a_t        cfg_a_q, cfg_a_d;
  cfg_b_t        cfg_b_q, cfg_b_d;
  logic          tone_q, tone_d;
  logic [CW-1:0] code_q, code_d;
  logic          err_q, err_d;

  logic          wr_a, wr_b, wr_tx, tx_take;
  logic [CW-1:0] chk_field;
  logic          chk_off, chk_bad;

  assign wr_a    = wr_stb && (reg_sel == REG_CFG_A);
  assign wr_b    = wr_stb && (reg_sel == REG_CFG_B);
  assign wr_tx   = wr_stb && (reg_sel == REG_TXCMD);
  assign tx_take = wr_tx && cfg_a_q.en;

  mf_code_check #(.CW(CW), .BW(BW)) u_chk (
    .cmd      (wdata),
    .bin_mode (cfg_a_q.bin),
    .field    (chk_field),
    .is_off   (chk_off),
    .is_bad   (chk_bad)
  );

  // next-state
  always_comb begin
    cfg_a_d = cfg_a_q;
    cfg_b_d = cfg_b_q;
    tone_d  = tone_q;
    code_d  = code_q;
    err_d   = err_q;
    if (wr_a) cfg_a_d = cfg_a_t'(wdata[$bits(cfg_a_t)-1:0]);
    if (wr_b) cfg_b_d = cfg_b_t'(wdata[$bits(cfg_b_t)-1:0]);
    if (tx_take) begin
      if (chk_off) begin
        tone_d = 1'b0;
        code_d = '0;
        err_d  = 1'b0;
      end else if (chk_bad) begin
        err_d  = 1'b1;
      end else begin
        tone_d = 1'b1;
        code_d = chk_field;
        err_d  = 1'b0;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_a_q <= '0;
      cfg_b_q <= '0;
      tone_q  <= 1'b0;
      code_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      if (wr_a)    cfg_a_q <= cfg_a_d;
      if (wr_b)    cfg_b_q <= cfg_b_d;
      if (tx_take) begin
        tone_q <= tone_d;
        code_q <= code_d;
        err_q  <= err_d;
      end
    end
  end

  assign cfg_a     = cfg_a_q;
  assign cfg_b     = cfg_b_q;
  assign tone_on   = tone_q;
  assign tone_code = code_q;

  always_comb begin
    reg_view = '0;
    reg_view[0*BYTE_W +: $bits(cfg_a_t)] = cfg_a_q;
    reg_view[1*BYTE_W +: $bits(cfg_b_t)] = cfg_b_q;
    reg_view[2*BYTE_W +: CW]             = code_q;
    reg_view[3*BYTE_W +: 2]              = {err_q, tone_q};
  end

  // R9: a command to a disabled channel touches nothing
  a_r9_disabled_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && !cfg_a_q.en) |=> ($stable(tone_q) && $stable(code_q) && $stable(err_q)));

  // R6: malformed 2-of-6 code raises the error and keeps the tone
  a_r6_bad_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && !cfg_a_q.bin && chk_bad) |=> (err_q && $stable(tone_q) && $stable(code_q)));

  // R8: zero field on an enabled channel stops the tone
  a_r8_off_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && chk_off) |=> (!tone_q && code_q == '0 && !err_q));

  // R10: the tone moves only on a transmit command
  a_r10_tone_only_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_tx |=> ($stable(tone_q) && $stable(code_q)));

  // R5: a running tone in 2-of-6 mode carries exactly two frequencies
  a_r5_two_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && !cfg_a_q.bin && !chk_off && !chk_bad) |=> ($countones(code_q) == 2));

  // R2/R3: config holds without its own write
  a_r2_cfg_a_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_a |=> $stable(cfg_a_q));
  a_r3_cfg_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_b |=> $stable(cfg_b_q));

endmodule

// File: rtl/mf_rd_mux.sv
module mf_rd_mux
  import mf_ctrl_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_stb,
  input  logic [CH_W-1:0]          ch_idx,
  input  reg_sel_e                 reg_sel,
  input  logic [NUM_CH*VIEW_W-1:0] views,
  output logic [BYTE_W-1:0]        rdata
);

  logic [BYTE_W-1:0] rdata_q, rdata_d, pick;

  always_comb begin
    pick = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_idx == CH_W'(c)) begin
        pick = views[c*VIEW_W + int'(reg_sel)*BYTE_W +: BYTE_W];
      end
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_stb) rdata_d = pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_stb) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;

  // R11: read data holds between reads
  a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rdata_q));

endmodule

// File: rtl/mf_ctrl_port.sv
module mf_ctrl_port
  import mf_ctrl_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int AW    = CH_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_sel,
  input  logic                     bus_we,
  input  logic [AW-1:0]            bus_addr,
  input  logic [BYTE_W-1:0]        bus_wdata,
  output logic [BYTE_W-1:0]        bus_rdata,
  output logic [NUM_CH-1:0]        tone_on,
  output logic [NUM_CH*CODE_W-1:0] tone_code,
  output logic [NUM_CH-1:0]        cfg_ext_clk,
  output logic [NUM_CH-1:0]        cfg_bin,
  output logic [NUM_CH-1:0]        cfg_en,
  output logic [NUM_CH-1:0]        cfg_kp_long,
  output logic [NUM_CH-1:0]        cfg_kp_gate,
  output logic [NUM_CH-1:0]        cfg_alaw
);

  logic [CH_W-1:0]          ch_idx;
  reg_sel_e                 reg_sel;
  logic                     wr_any, rd_any;
  logic [NUM_CH*VIEW_W-1:0] views;

  assign ch_idx  = bus_addr[AW-1:2];
  assign reg_sel = reg_sel_e'(bus_addr[1:0]);
  assign wr_any  = bus_sel && bus_we;
  assign rd_any  = bus_sel && !bus_we;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    cfg_a_t ca;
    cfg_b_t cb;
    logic   wr_this;

    assign wr_this = wr_any && (ch_idx == CH_W'(g));

    mf_chan_bank #(.CW(CODE_W), .BW(BIN_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stb    (wr_this),
      .reg_sel   (reg_sel),
      .wdata     (bus_wdata),
      .cfg_a     (ca),
      .cfg_b     (cb),
      .tone_on   (tone_on[g]),
      .tone_code (tone_code[g*CODE_W +: CODE_W]),
      .reg_view  (views[g*VIEW_W +: VIEW_W])
    );

    assign cfg_en[g]      = ca.en;
    assign cfg_bin[g]     = ca.bin;
    assign cfg_alaw[g]    = ca.alaw;
    assign cfg_ext_clk[g] = cb.ext_clk;
    assign cfg_kp_long[g] = cb.kp_long;
    assign cfg_kp_gate[g] = cb.kp_gate;
  end

  mf_rd_mux #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_stb  (rd_any),
    .ch_idx  (ch_idx),
    .reg_sel (reg_sel),
    .views   (views),
    .rdata   (bus_rdata)
  );

  // R12: nothing moves without a bus select
  a_r12_no_sel_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> ($stable(cfg_en) && $stable(cfg_bin) && $stable(cfg_alaw) &&
                  $stable(cfg_ext_clk) && $stable(tone_on) && $stable(bus_rdata)));

  // R4: a write to one channel leaves the other alone
  a_r4_other_ch_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && ch_idx == CH_W'(0)) |=> ($stable(tone_on[NUM_CH-1]) && $stable(cfg_en[NUM_CH-1])));

endmodule

// File: tb/tb_mf_ctrl_port.sv
module tb_mf_ctrl_port;

  logic        clk;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [2:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [1:0]  tone_on;
  logic [11:0] tone_code;
  logic [1:0]  cfg_ext_clk, cfg_bin, cfg_en, cfg_kp_long, cfg_kp_gate, cfg_alaw;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  mf_ctrl_port dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tone_on(tone_on), .tone_code(tone_code), .cfg_ext_clk(cfg_ext_clk),
    .cfg_bin(cfg_bin), .cfg_en(cfg_en), .cfg_kp_long(cfg_kp_long),
    .cfg_kp_gate(cfg_kp_gate), .cfg_alaw(cfg_alaw)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    chk(tone_on == 0, "R1 tone_on", tone_on, 0);
    chk(tone_code == 0, "R1 tone_code", tone_code, 0);
    chk({cfg_ext_clk, cfg_bin, cfg_en, cfg_kp_long, cfg_kp_gate, cfg_alaw} == 0, "R1 cfg",
        {cfg_ext_clk, cfg_bin, cfg_en, cfg_kp_long, cfg_kp_gate, cfg_alaw}, 0);
    chk(bus_rdata == 0, "R1 rdata", bus_rdata, 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk(d == 0, "R1 readback", d, 0);
    end
  endtask

  task automatic t_cfg_a();
    logic [7:0] d;
    do_reset();
    wr(3'd0, 8'hFD);
    chk(cfg_en[0] == 1 && cfg_bin[0] == 0 && cfg_alaw[0] == 1, "R2 cfgA fd",
        {cfg_alaw[0], cfg_bin[0], cfg_en[0]}, 3'b101);
    rd(3'd0, d);
    chk(d == 8'h05, "R2 R11 cfgA read", d, 8'h05);
    wr(3'd0, 8'h02);
    chk(cfg_en[0] == 0 && cfg_bin[0] == 1 && cfg_alaw[0] == 0, "R2 cfgA 02",
        {cfg_alaw[0], cfg_bin[0], cfg_en[0]}, 3'b010);
  endtask

  task automatic t_cfg_b();
    logic [7:0] d;
    do_reset();
    wr(3'd1, 8'hFA);
    chk({cfg_kp_gate[0], cfg_kp_long[0], cfg_ext_clk[0]} == 3'b010, "R3 cfgB fa",
        {cfg_kp_gate[0], cfg_kp_long[0], cfg_ext_clk[0]}, 3'b010);
    rd(3'd1, d);
    chk(d == 8'h02, "R3 R11 cfgB read", d, 8'h02);
    wr(3'd1, 8'h05);
    chk({cfg_kp_gate[0], cfg_kp_long[0], cfg_ext_clk[0]} == 3'b101, "R3 cfgB 05",
        {cfg_kp_gate[0], cfg_kp_long[0], cfg_ext_clk[0]}, 3'b101);
  endtask

  task automatic t_chan_iso();
    logic [7:0] d;
    do_reset();
    wr(3'd4, 8'h03);
    chk(cfg_en == 2'b10 && cfg_bin == 2'b10, "R4 ch1 cfg", {cfg_en, cfg_bin}, 4'b1010);
    wr(3'd6, 8'h05);
    chk(tone_on == 2'b10 && tone_code == 12'h140, "R4 ch1 tone", {tone_on, tone_code}, {2'b10, 12'h140});
    rd(3'd0, d);
    chk(d == 0, "R4 ch0 cfg untouched", d, 0);
    wr(3'd5, 8'h07);
    chk(cfg_kp_gate == 2'b10 && cfg_ext_clk == 2'b10, "R4 ch1 cfgB", {cfg_kp_gate, cfg_ext_clk}, 4'b1010);
  endtask

  task automatic t_2of6();
    logic [7:0] d;
    do_reset();
    wr(3'd0, 8'h01);
    wr(3'd2, 8'hC3);
    chk(tone_on[0] == 1 && tone_code[5:0] == 6'h03, "R5 tone 03", {tone_on[0], tone_code[5:0]}, 7'h43);
    wr(3'd2, 8'h28);
    chk(tone_on[0] == 1 && tone_code[5:0] == 6'h28, "R5 tone 28", tone_code[5:0], 6'h28);
    rd(3'd2, d);
    chk(d == 8'h28, "R5 R11 cmd read", d, 8'h28);
    rd(3'd3, d);
    chk(d == 8'h01, "R5 status", d, 8'h01);
  endtask

  task automatic t_bad();
    logic [7:0] d;
    do_reset();
    wr(3'd0, 8'h01);
    wr(3'd2, 8'h03);
    wr(3'd2, 8'h07);
    chk(tone_on[0] == 1 && tone_code[5:0] == 6'h03, "R6 three bits kept", tone_code[5:0], 6'h03);
    rd(3'd3, d);
    chk(d == 8'h03, "R6 err set", d, 8'h03);
    wr(3'd2, 8'h10);
    chk(tone_code[5:0] == 6'h03, "R6 one bit kept", tone_code[5:0], 6'h03);
    wr(3'd2, 8'h21);
    rd(3'd3, d);
    chk(d == 8'h01 && tone_code[5:0] == 6'h21, "R8 err cleared by accept", {d, 2'b0, tone_code[5:0]}, {8'h01, 8'h21});
  endtask

  task automatic t_binary();
    logic [7:0] d;
    do_reset();
    wr(3'd0, 8'h03);
    wr(3'd2, 8'hF9);
    chk(tone_on[0] == 1 && tone_code[5:0] == 6'h09, "R7 bin 9", tone_code[5:0], 6'h09);
    wr(3'd2, 8'h0F);
    chk(tone_code[5:0] == 6'h0F, "R7 bin F", tone_code[5:0], 6'h0F);
    rd(3'd3, d);
    chk(d == 8'h01, "R7 no err", d, 8'h01);
    wr(3'd2, 8'h30);
    chk(tone_on[0] == 0 && tone_code[5:0] == 0, "R8 bin off", {tone_on[0], tone_code[5:0]}, 0);
  endtask

  task automatic t_off();
    logic [7:0] d;
    do_reset();
    wr(3'd0, 8'h01);
    wr(3'd2, 8'h05);
    wr(3'd2, 8'h3F);
    wr(3'd2, 8'hC0);
    chk(tone_on[0] == 0 && tone_code[5:0] == 0, "R8 off", {tone_on[0], tone_code[5:0]}, 0);
    rd(3'd3, d);
    chk(d == 0, "R8 status clear", d, 0);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    do_reset();
    wr(3'd2, 8'h03);
    chk(tone_on == 0 && tone_code == 0, "R9 no start", {tone_on, tone_code}, 0);
    wr(3'd2, 8'h07);
    rd(3'd3, d);
    chk(d == 0, "R9 no err", d, 0);
  endtask

  task automatic t_disable_on();
    logic [7:0] d;
    do_reset();
    wr(3'd0, 8'h01);
    wr(3'd2, 8'h06);
    wr(3'd0, 8'h00);
    chk(tone_on[0] == 1 && tone_code[5:0] == 6'h06, "R10 tone survives disable", tone_code[5:0], 6'h06);
    wr(3'd2, 8'h00);
    chk(tone_on[0] == 1, "R9 R10 off ignored when disabled", tone_on[0], 1);
    wr(3'd2, 8'h18);
    rd(3'd2, d);
    chk(d == 8'h06, "R9 code kept", d, 8'h06);
    wr(3'd0, 8'h01);
    wr(3'd2, 8'h00);
    chk(tone_on[0] == 0, "R10 off after enable", tone_on[0], 0);
  endtask

  task automatic t_nosel();
    logic [7:0] d;
    do_reset();
    wr(3'd0, 8'h05);
    rd(3'd0, d);
    bus_sel = 0; bus_we = 1; bus_addr = 3'd0; bus_wdata = 8'h02;
    @(negedge clk);
    bus_we = 0;
    chk(cfg_en[0] == 1 && cfg_alaw[0] == 1 && cfg_bin[0] == 0, "R12 unselected write",
        {cfg_alaw[0], cfg_bin[0], cfg_en[0]}, 3'b101);
    bus_addr = 3'd3;
    repeat (2) @(negedge clk);
    chk(bus_rdata == 8'h05, "R11 rdata holds", bus_rdata, 8'h05);
  endtask

  initial begin
    rst_n = 0;
    t_reset();
    t_cfg_a();
    t_cfg_b();
    t_chan_iso();
    t_2of6();
    t_bad();
    t_binary();
    t_off();
    t_disabled();
    t_disable_on();
    t_nosel();
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule